// File: doc/BRIEF.md
# Supply-Monitor Reset Pulse Generator

This block produces the active-low processor reset for a supervised system. It combines three reasons for holding the processor in reset: a digital supply-good flag coming from an analog comparator elsewhere, an external manual or electronic reset request line, and a request pulse from a watchdog timer. A single hold engine stretches every cause into a reset pulse of a guaranteed minimum length, counted in pulses of a 1 ms tick input.

A low supply-good flag pulls reset low in the same cycle, with no wait for a clock tick or a count, and keeps it low as long as the flag stays low. When the flag returns, reset stays low for a programmable number of ticks (700 by default, giving a hold between 500 and 900 ms). The external request line is asynchronous. It passes through a two-flop synchronizer and a debouncer, and it is accepted only after a low level that lasts a programmable number of ticks (20 by default). A watchdog request pulse starts the same stretched pulse. Any new cause that arrives during a pulse reloads the full hold count. A one-cycle release pulse marks the first cycle that reset is high again, so the watchdog can restart its period.

Top module: `supv_reset_gen`

## Requirements
- R1: While `supply_ok` is low, `reset_n` is low in that same cycle, with or without ticks.
- R2: After `supply_ok` returns high, `reset_n` stays low until HOLD_TICKS tick pulses have been sampled with `supply_ok` high. It goes high in the cycle after the edge that samples the last of them.
- R3: After the synchronous reset `rst`, `reset_n` is low and follows the hold of R2, counted from the end of `rst`.
- R4: `ext_req_n` low (0 = request) is accepted once DEB_TICKS ticks have been sampled while its synchronized level is low. Fewer ticks leave `reset_n` high.
- R5: If `ext_req_n` goes back high before it is accepted, the qualification count starts again from zero.
- R6: An accepted external request holds `reset_n` low for HOLD_TICKS ticks, even if the request line is released at once.
- R7: A request line held low yields only one pulse. `reset_n` stays high after that pulse until the line has gone high and qualified again.
- R8: A one-cycle `wdog_req` drives `reset_n` low from the next cycle for HOLD_TICKS ticks.
- R9: A cause that arrives while a pulse is running reloads the full HOLD_TICKS count.
- R10: `release_pulse` is high for exactly one cycle, the first cycle in which `reset_n` is high again, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1ms | input | 1 | One-cycle pulse per millisecond |
| supply_ok | input | 1 | Supply-good flag, synchronous to clk, 1 = in tolerance |
| ext_req_n | input | 1 | Asynchronous external reset request, active low |
| wdog_req | input | 1 | One-cycle watchdog reset request |
| reset_n | output | 1 | Active-low processor reset |
| release_pulse | output | 1 | One-cycle pulse in the first cycle reset_n is high |

## Verification
The assertions take `supply_ok` and `wdog_req` to be synchronous to `clk`, and take `tick_1ms` to be a single-cycle pulse. They also take it that no release happens without a tick. The bench drives every input at the falling edge, so each value is sampled by exactly one rising edge. Ticks are one cycle wide with idle gaps between them. The external line is held at a new level for several cycles before any tick, so the synchronizer delay never decides which tick is counted.

// File: rtl/supv_pkg.sv
package supv_pkg;

    // width of a down counter able to hold the value n
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    // qualification state of the manual request
    typedef enum logic {
        DB_ARMED = 1'b0,
        DB_SPENT = 1'b1
    } db_state_e;

    // source that loaded the hold engine, in priority order
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_SUPPLY = 2'd1,
        SRC_MANUAL = 2'd2,
        SRC_WDOG   = 2'd3
    } load_src_e;

    function automatic load_src_e pick_src(input logic sup_bad,
                                           input logic man,
                                           input logic wd);
        if (sup_bad) return SRC_SUPPLY;
        if (man)     return SRC_MANUAL;
        if (wd)      return SRC_WDOG;
        return SRC_NONE;
    endfunction

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
    parameter int STAGES   = 2,
    parameter bit IDLE_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= IDLE_VAL;
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{IDLE_VAL}};
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/supv_debounce.sv
module supv_debounce
    import supv_pkg::*;
#(
    parameter int DEB_TICKS = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic level_n,
    output logic accept
);
    localparam int CW = cnt_width(DEB_TICKS);
    localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);

    db_state_e     state;
    logic [CW-1:0] seen;
    logic          accept_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= DB_ARMED;
            seen     <= '0;
            accept_q <= 1'b0;
        end else begin
            accept_q <= 1'b0;
            if (level_n) begin
                state <= DB_ARMED;
                seen  <= '0;
            end else if (tick && state == DB_ARMED) begin
                if (seen == LAST) begin
                    accept_q <= 1'b1;
                    state    <= DB_SPENT;
                    seen     <= '0;
                end else begin
                    seen <= seen + 1'b1;
                end
            end
        end
    end

    assign accept = accept_q;
endmodule

// File: rtl/supv_hold.sv
module supv_hold
    import supv_pkg::*;
#(
    parameter int HOLD_TICKS = 700
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic supply_ok,
    input  logic man_accept,
    input  logic wd_req,
    output logic active,
    output logic release_q
);
    localparam int CW = cnt_width(HOLD_TICKS);
    localparam logic [CW-1:0] FULL = CW'(HOLD_TICKS);

    logic [CW-1:0] left;
    logic          act_q;
    logic          rel_q;
    load_src_e     src;

    always_comb src = pick_src(!supply_ok, man_accept, wd_req);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b1;
            left  <= FULL;
            rel_q <= 1'b0;
        end else begin
            rel_q <= 1'b0;
            if (src != SRC_NONE) begin
                act_q <= 1'b1;
                left  <= FULL;
            end else if (act_q && tick) begin
                if (left <= CW'(1)) begin
                    act_q <= 1'b0;
                    left  <= '0;
                    rel_q <= 1'b1;
                end else begin
                    left <= left - 1'b1;
                end
            end
        end
    end

    assign active    = act_q;
    assign release_q = rel_q;
endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen #(
    parameter int HOLD_TICKS  = 700,
    parameter int DEB_TICKS   = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_1ms,
    input  logic supply_ok,
    input  logic ext_req_n,
    input  logic wdog_req,
    output logic reset_n,
    output logic release_pulse
);
    logic ext_sync_n;
    logic man_accept;
    logic hold_active;
    logic hold_release;

    supv_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ext_req_n),
        .q   (ext_sync_n)
    );

    supv_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_1ms),
        .level_n (ext_sync_n),
        .accept  (man_accept)
    );

    supv_hold #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick_1ms),
        .supply_ok  (supply_ok),
        .man_accept (man_accept),
        .wd_req     (wdog_req),
        .active     (hold_active),
        .release_q  (hold_release)
    );

    // supply fault bypasses every register on the way to the pin
    assign reset_n       = supply_ok & ~hold_active;
    assign release_pulse = hold_release;
endmodule

// File: rtl/supv_reset_gen_chk.sv
module supv_reset_gen_chk (
    input logic clk,
    input logic rst,
    input logic tick_1ms,
    input logic supply_ok,
    input logic wdog_req,
    input logic reset_n,
    input logic release_pulse
);
    assert_supply_forces_R1: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |-> !reset_n);

    assert_release_needs_tick_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(reset_n) |-> $past(tick_1ms));

    assert_wdog_starts_R8: assert property (@(posedge clk) disable iff (rst)
        wdog_req |=> !reset_n);

    assert_reload_keeps_low_R9: assert property (@(posedge clk) disable iff (rst)
        (wdog_req && !reset_n) |=> !reset_n);

    assert_release_on_rise_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(reset_n) |-> release_pulse);

    assert_release_only_rise_R10: assert property (@(posedge clk) disable iff (rst)
        release_pulse |-> $rose(reset_n));
endmodule

bind supv_reset_gen supv_reset_gen_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .tick_1ms      (tick_1ms),
    .supply_ok     (supply_ok),
    .wdog_req      (wdog_req),
    .reset_n       (reset_n),
    .release_pulse (release_pulse)
);

// File: tb/sim_supv_reset_gen.sv
`timescale 1ns/1ps
module sim_supv_reset_gen;
    localparam int HOLD = 4;
    localparam int DEB  = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_1ms = 1'b0;
    logic supply_ok = 1'b1;
    logic ext_req_n = 1'b1;
    logic wdog_req = 1'b0;
    logic reset_n;
    logic release_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    supv_reset_gen #(.HOLD_TICKS(HOLD), .DEB_TICKS(DEB), .SYNC_STAGES(2)) u0 (
        .clk           (clk),
        .rst           (rst),
        .tick_1ms      (tick_1ms),
        .supply_ok     (supply_ok),
        .ext_req_n     (ext_req_n),
        .wdog_req      (wdog_req),
        .reset_n       (reset_n),
        .release_pulse (release_pulse)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one-cycle tick, then gap idle cycles; returns at a falling edge
    task automatic tick(input int gap);
        tick_1ms = 1'b1;
        step(1);
        tick_1ms = 1'b0;
        step(gap);
    endtask

    // after a cause: HOLD-1 ticks keep reset low, the last one releases it
    task automatic expect_hold(input string req, input int gap);
        for (int k = 0; k < HOLD - 1; k++) begin
            tick(gap);
            check(req, reset_n, 1'b0);
        end
        tick_1ms = 1'b1;
        step(1);
        tick_1ms = 1'b0;
        check(req, reset_n, 1'b1);
        check("R10", release_pulse, 1'b1);
        step(1);
        check("R10", release_pulse, 1'b0);
        check(req, reset_n, 1'b1);
        step(gap);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        step(4);
        rst = 1'b0;
        step(1);
        // R3: power-up hold
        check("R3", reset_n, 1'b0);
        check("R3", release_pulse, 1'b0);
        expect_hold("R3", 2);

        // R1/R2: supply dropout swept over dropout length and tick spacing
        for (int gap = 1; gap <= 3; gap++) begin
            for (int len = 1; len <= 3; len++) begin
                @(negedge clk);
                supply_ok = 1'b0;
                #1 check("R1", reset_n, 1'b0);
                // ticks during the fault change nothing
                tick(len);
                check("R1", reset_n, 1'b0);
                supply_ok = 1'b1;
                step(1);
                check("R2", reset_n, 1'b0);
                expect_hold("R2", gap);
            end
        end

        // R4: DEB-1 ticks while low are not enough, one more is accepted
        for (int gap = 1; gap <= 2; gap++) begin
            ext_req_n = 1'b0;
            step(4);
            for (int k = 0; k < DEB - 1; k++) tick(gap);
            step(3);
            check("R4", reset_n, 1'b1);
            tick(0);
            step(2);
            check("R4", reset_n, 1'b0);
            // R6: released at once, hold still full length
            ext_req_n = 1'b1;
            step(3);
            expect_hold("R6", gap);
        end

        // R5: bounce high before acceptance restarts the count
        ext_req_n = 1'b0;
        step(4);
        for (int k = 0; k < DEB - 1; k++) tick(1);
        ext_req_n = 1'b1;
        step(4);
        ext_req_n = 1'b0;
        step(4);
        for (int k = 0; k < DEB - 1; k++) tick(1);
        step(3);
        check("R5", reset_n, 1'b1);
        tick(0);
        step(2);
        check("R5", reset_n, 1'b0);
        // R7: line stays low; after one pulse no second one
        expect_hold("R6", 1);
        for (int k = 0; k < DEB + HOLD + 2; k++) begin
            tick(1);
            check("R7", reset_n, 1'b1);
        end
        ext_req_n = 1'b1;
        step(4);

        // R8: watchdog request
        wdog_req = 1'b1;
        step(1);
        wdog_req = 1'b0;
        check("R8", reset_n, 1'b0);
        expect_hold("R8", 2);

        // R9: reload partway through, swept over the reload point
        for (int at = 1; at < HOLD; at++) begin
            wdog_req = 1'b1;
            step(1);
            wdog_req = 1'b0;
            for (int k = 0; k < at; k++) tick(1);
            check("R9", reset_n, 1'b0);
            wdog_req = 1'b1;
            step(1);
            wdog_req = 1'b0;
            expect_hold("R9", 1);
        end

        // R9: supply dip without ticks during a pulse reloads too
        wdog_req = 1'b1;
        step(1);
        wdog_req = 1'b0;
        tick(1);
        tick(1);
        supply_ok = 1'b0;
        step(2);
        supply_ok = 1'b1;
        step(1);
        expect_hold("R9", 1);

        // R10: idle with ticks, no release pulse and reset stays high
        for (int k = 0; k < 6; k++) begin
            tick(1);
            check("R10", release_pulse, 1'b0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule